// File: doc/BRIEF.md
# Sync-Framed Serial Voice Port

This block is the digital serial front end of a voice-band transcoder. It moves samples over two independent bit clocks. A PCM bit clock carries speech samples, and an ADPCM bit clock carries 4-bit compressed codes. Each direction has its own frame sync pulse, and that pulse marks the first (most significant) bit of every word in the frame.

In the transmit direction, the block takes a parallel PCM word and a parallel ADPCM code and shifts both out. In the receive direction, it assembles a serial PCM word and a serial ADPCM code into parallel registers, and raises a one-period valid strobe for each. A law-select input chooses the PCM word length for each frame: 8-bit companded characters or 14-bit two's-complement linear samples. The ADPCM output models an open-drain line, expressed as a pull-low request. A power-down input silences the port, and a synchronous reset clears it. Transcoding, companding arithmetic and analog functions are handled elsewhere.

Top module: `vox_serial_port`

## Requirements
- R1: While `rst_n` is low across at least one edge of each bit clock, the port clears its state. After reset, `pcm_tx_oe`, `adp_tx_pull`, `rx_pcm_vld` and `rx_adp_vld` are 0, and both received words read zero.
- R2: A frame starts at the first falling bit-clock edge that sees its sync high after seeing it low at the previous falling edge. A sync held high over several falling edges does not restart the frame.
- R3: Transmit PCM launches its most significant bit on the rising `pcm_bclk` edge that follows the frame-start falling edge. It then moves one bit per rising edge, most significant first. `pcm_tx_oe` stays high for exactly the word length in bit periods and then drops until the next frame.
- R4: `lin_sel` is sampled at frame start. With `lin_sel`=1, words are 14 bits and carry `tx_pcm_word[13:0]`. With `lin_sel`=0, words are 8 bits: transmit sends `tx_pcm_word[7:0]`, and receive returns the character in `rx_pcm_word[7:0]` with bits 13:8 zero.
- R5: Linear words pass bit-exact, including positive full scale 01111111111111, negative full scale 10000000000000 and zero.
- R6: The ADPCM code leaves most significant bit first. Its first bit launches on the rising `adp_bclk` edge after the frame-start falling edge, with one bit per period for 4 periods. `adp_tx_pull` is 1 while the current bit is 0 and 0 while it is 1. The line is released (`adp_tx_pull`=0) before and after those 4 periods.
- R7: Serial inputs are sampled on falling edges. The first sample is taken on the frame-start falling edge itself. On the falling edge that samples the last bit, the word appears in parallel with its valid strobe high for exactly one bit period.
- R8: Bit clocks and data that follow the last bit of a frame are ignored: no further strobe, and the word is unchanged.
- R9: A received word holds its value through idle periods and through power-down, until the next completed capture or a reset.
- R10: While `pdn_n` is low, `pcm_tx_oe` and `adp_tx_pull` are 0 at once, without waiting for a clock edge. Any frame in progress is abandoned, and no frame starts or completes. After `pdn_n` returns high, the next sync starts a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcm_bclk | input | 1 | PCM bit clock |
| adp_bclk | input | 1 | ADPCM bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pdn_n | input | 1 | Power-down, active low |
| lin_sel | input | 1 | 1: 14-bit linear words, 0: 8-bit companded words |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_fsync | input | 1 | Receive frame sync |
| tx_pcm_word | input | 14 | Parallel PCM word to transmit |
| tx_adp_code | input | 4 | Parallel ADPCM code to transmit |
| pcm_tx_sd | output | 1 | Transmit PCM serial data |
| pcm_tx_oe | output | 1 | Transmit PCM driver enable |
| adp_tx_pull | output | 1 | Open-drain ADPCM output: 1 pulls the line low |
| pcm_rx_sd | input | 1 | Receive PCM serial data |
| adp_rx_sd | input | 1 | Receive ADPCM serial data |
| rx_pcm_word | output | 14 | Last received PCM word |
| rx_pcm_vld | output | 1 | One-period strobe for a new PCM word |
| rx_adp_code | output | 4 | Last received ADPCM code |
| rx_adp_vld | output | 1 | One-period strobe for a new ADPCM code |

## Verification
A corrupted transmit bit counter shows up within the same frame. The enable window comes out shorter or longer than the word, and it is visible at the bit period where the last bit should have been. A start flag that fires twice, or one that misses the sync edge, shifts the whole word by one period, and this is visible on the first launch edge after the sync. A receive counter that drifts moves or suppresses the valid strobe by the falling edge of the last bit. Because the scoreboard queues each expected bit and word, a misaligned or extra strobe becomes an unexpected pop within one bit period.

// File: rtl/vox_port_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial voice port.
package vox_port_pkg;
    localparam int PCM_LIN_W_DEF = 14;
    localparam int PCM_CMP_W_DEF = 8;
    localparam int ADP_W_DEF     = 4;

    // Word framing chosen by the law-select input.
    typedef enum logic {
        LAW_CMP = 1'b0,
        LAW_LIN = 1'b1
    } law_e;
endpackage

// File: rtl/vox_tx_lane.sv
`timescale 1ns/1ps
// Serial transmit lane.
// Detects the rising edge of the frame sync on the falling bit-clock edge,
// loads the parallel word on the next rising edge (left aligned, so the
// first bit sent is word_i[len_i-1]) and shifts it out MSB first, one bit
// per rising edge, for len_i periods.
// Assumes: fsync, len_i and word_i are synchronous to bclk and stable
// around the frame start; len_i >= 1 and len_i <= W.
module vox_tx_lane #(
    parameter int W = 14
) (
    input  logic                     bclk,
    input  logic                     rst_n,
    input  logic                     pdn_n,
    input  logic                     fsync,
    input  logic [$clog2(W+1)-1:0]   len_i,
    input  logic [W-1:0]             word_i,
    output logic                     sd_o,
    output logic                     oe_o
);
    localparam int CW = $clog2(W+1);

    logic          sync_d_q;
    logic          start_q;
    logic          oe_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  sh_q;
    logic [CW-1:0] pad;

    assign pad = CW'(W) - len_i;

    // Sync edge detection on the sampling (falling) edge.
    always_ff @(negedge bclk) begin
        if (!rst_n) begin
            sync_d_q <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            sync_d_q <= fsync;
            start_q  <= fsync & ~sync_d_q & pdn_n;
        end
    end

    // Load, shift and bit counting on the launch (rising) edge.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (!pdn_n) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
        end else if (start_q) begin
            sh_q  <= word_i << pad;
            cnt_q <= len_i - 1'b1;
            oe_q  <= 1'b1;
        end else if (oe_q) begin
            if (cnt_q == '0) begin
                oe_q <= 1'b0;
            end else begin
                sh_q  <= sh_q << 1;
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Power-down releases the pin without waiting for a clock.
    assign oe_o = oe_q & pdn_n;
    assign sd_o = oe_o & sh_q[W-1];

    // R2: the enable only rises after a detected sync edge.
    p_load_after_start_r2: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(start_q))
        else $error("tx lane enable rose without a frame start");

    // R3: the window closes right after the last counted bit.
    p_frame_end_r3: assert property (@(posedge bclk) disable iff (!rst_n)
        (oe_q && cnt_q == '0 && !start_q && pdn_n) |=> !oe_q)
        else $error("tx lane kept driving past the last bit");

    // R10: power-down clears the frame state on the next edge.
    p_pd_release_r10: assert property (@(posedge bclk) disable iff (!rst_n)
        !pdn_n |=> !oe_q)
        else $error("tx lane still framing in power-down");
endmodule

// File: rtl/vox_rx_lane.sv
`timescale 1ns/1ps
// Serial receive lane.
// All state changes on the falling bit-clock edge. The edge that sees a
// sync rise takes the first (MSB) sample; len_i samples in total are
// shifted in, then the word is published with a one-period strobe.
// The shifter is cleared at frame start, so a short word arrives
// right aligned with zero upper bits.
// Assumes: 2 <= len_i <= W, inputs synchronous to bclk.
module vox_rx_lane #(
    parameter int W = 14
) (
    input  logic                     bclk,
    input  logic                     rst_n,
    input  logic                     pdn_n,
    input  logic                     fsync,
    input  logic                     sd_i,
    input  logic [$clog2(W+1)-1:0]   len_i,
    output logic [W-1:0]             word_o,
    output logic                     vld_o
);
    localparam int CW = $clog2(W+1);

    logic          sync_d_q;
    logic          busy_q;
    logic          vld_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [W-1:0]  sh_q;
    logic [W-1:0]  word_q;
    logic [W-1:0]  sh_nx;

    assign sh_nx = {sh_q[W-2:0], sd_i};

    // Frame detection, sampling, counting and word publication.
    always_ff @(negedge bclk) begin
        if (!rst_n) begin
            sync_d_q <= 1'b0;
            busy_q   <= 1'b0;
            vld_q    <= 1'b0;
            cnt_q    <= '0;
            len_q    <= '0;
            sh_q     <= '0;
            word_q   <= '0;
        end else begin
            sync_d_q <= fsync;
            vld_q    <= 1'b0;
            if (!pdn_n) begin
                busy_q <= 1'b0;
            end else if (fsync && !sync_d_q) begin
                sh_q   <= {{(W-1){1'b0}}, sd_i};
                cnt_q  <= CW'(1);
                len_q  <= len_i;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                sh_q  <= sh_nx;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q + 1'b1 == len_q) begin
                    busy_q <= 1'b0;
                    vld_q  <= 1'b1;
                    word_q <= sh_nx;
                end
            end
        end
    end

    assign word_o = word_q;
    assign vld_o  = vld_q;

    // R7: the strobe lasts exactly one bit period.
    p_vld_single_r7: assert property (@(negedge bclk) disable iff (!rst_n)
        vld_q |=> !vld_q)
        else $error("rx strobe longer than one period");

    // R8: a strobe only closes a frame that was in progress.
    p_vld_in_frame_r8: assert property (@(negedge bclk) disable iff (!rst_n)
        vld_q |-> $past(busy_q))
        else $error("rx strobe outside a frame");

    // R7: the sample count never reaches the latched length while busy.
    p_cnt_bound_r7: assert property (@(negedge bclk) disable iff (!rst_n)
        busy_q |-> (cnt_q < len_q))
        else $error("rx sample count overran word length");
endmodule

// File: rtl/vox_serial_port.sv
`timescale 1ns/1ps
// Sync-framed serial voice port.
// Four lanes: PCM and ADPCM transmit framed by tx_fsync, PCM and ADPCM
// receive framed by rx_fsync. PCM lanes run on pcm_bclk with a length
// picked per frame by lin_sel; ADPCM lanes run on adp_bclk with a fixed
// code width. The ADPCM transmit pin is open drain: it only ever
// requests a low level.
// Assumes: each sync is synchronous to both bit clocks.
module vox_serial_port
    import vox_port_pkg::*;
#(
    parameter int PCM_W  = PCM_LIN_W_DEF,
    parameter int PCM_NW = PCM_CMP_W_DEF,
    parameter int ADP_W  = ADP_W_DEF
) (
    input  logic              pcm_bclk,
    input  logic              adp_bclk,
    input  logic              rst_n,
    input  logic              pdn_n,
    input  logic              lin_sel,
    input  logic              tx_fsync,
    input  logic              rx_fsync,
    input  logic [PCM_W-1:0]  tx_pcm_word,
    input  logic [ADP_W-1:0]  tx_adp_code,
    output logic              pcm_tx_sd,
    output logic              pcm_tx_oe,
    output logic              adp_tx_pull,
    input  logic              pcm_rx_sd,
    input  logic              adp_rx_sd,
    output logic [PCM_W-1:0]  rx_pcm_word,
    output logic              rx_pcm_vld,
    output logic [ADP_W-1:0]  rx_adp_code,
    output logic              rx_adp_vld
);
    localparam int PCM_CW = $clog2(PCM_W+1);
    localparam int ADP_CW = $clog2(ADP_W+1);

    law_e              law;
    logic [PCM_CW-1:0] pcm_len;
    logic [ADP_CW-1:0] adp_len;
    logic              adp_sd;
    logic              adp_oe;

    // Word length from the selected framing law.
    assign law     = law_e'(lin_sel);
    assign pcm_len = (law == LAW_LIN) ? PCM_CW'(PCM_W) : PCM_CW'(PCM_NW);
    assign adp_len = ADP_CW'(ADP_W);

    vox_tx_lane #(.W(PCM_W)) u_pcm_tx (
        .bclk(pcm_bclk), .rst_n(rst_n), .pdn_n(pdn_n), .fsync(tx_fsync),
        .len_i(pcm_len), .word_i(tx_pcm_word),
        .sd_o(pcm_tx_sd), .oe_o(pcm_tx_oe)
    );

    vox_tx_lane #(.W(ADP_W)) u_adp_tx (
        .bclk(adp_bclk), .rst_n(rst_n), .pdn_n(pdn_n), .fsync(tx_fsync),
        .len_i(adp_len), .word_i(tx_adp_code),
        .sd_o(adp_sd), .oe_o(adp_oe)
    );

    // Open-drain model: pull low only for a driven zero bit.
    assign adp_tx_pull = adp_oe & ~adp_sd;

    vox_rx_lane #(.W(PCM_W)) u_pcm_rx (
        .bclk(pcm_bclk), .rst_n(rst_n), .pdn_n(pdn_n), .fsync(rx_fsync),
        .sd_i(pcm_rx_sd), .len_i(pcm_len),
        .word_o(rx_pcm_word), .vld_o(rx_pcm_vld)
    );

    vox_rx_lane #(.W(ADP_W)) u_adp_rx (
        .bclk(adp_bclk), .rst_n(rst_n), .pdn_n(pdn_n), .fsync(rx_fsync),
        .sd_i(adp_rx_sd), .len_i(adp_len),
        .word_o(rx_adp_code), .vld_o(rx_adp_vld)
    );
endmodule

// File: tb/vox_serial_port_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: frame tasks queue expected bits and words, and
// monitors pop and compare them as the port produces them.
module vox_serial_port_tb;
    logic        pcm_bclk = 1'b1;
    logic        adp_bclk = 1'b1;
    logic        rst_n = 1'b0, pdn_n = 1'b1, lin_sel = 1'b1;
    logic        tx_fsync = 1'b0, rx_fsync = 1'b0;
    logic [13:0] tx_pcm_word = '0;
    logic [3:0]  tx_adp_code = '0;
    logic        pcm_rx_sd = 1'b0, adp_rx_sd = 1'b0;
    logic        pcm_tx_sd, pcm_tx_oe, adp_tx_pull;
    logic [13:0] rx_pcm_word;
    logic        rx_pcm_vld;
    logic [3:0]  rx_adp_code;
    logic        rx_adp_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit         q_ptx[$];
    logic [3:0] q_atx[$];
    logic [13:0] q_prx[$];
    logic [3:0] q_arx[$];
    logic [13:0] held_prx = '0;
    logic [3:0]  held_arx = '0;

    always #2 pcm_bclk = ~pcm_bclk;   // 250 MHz, rises on multiples of 4 ns
    always #4 adp_bclk = ~adp_bclk;   // rises on multiples of 8 ns

    vox_serial_port u_dut (
        .pcm_bclk(pcm_bclk), .adp_bclk(adp_bclk), .rst_n(rst_n), .pdn_n(pdn_n),
        .lin_sel(lin_sel), .tx_fsync(tx_fsync), .rx_fsync(rx_fsync),
        .tx_pcm_word(tx_pcm_word), .tx_adp_code(tx_adp_code),
        .pcm_tx_sd(pcm_tx_sd), .pcm_tx_oe(pcm_tx_oe), .adp_tx_pull(adp_tx_pull),
        .pcm_rx_sd(pcm_rx_sd), .adp_rx_sd(adp_rx_sd),
        .rx_pcm_word(rx_pcm_word), .rx_pcm_vld(rx_pcm_vld),
        .rx_adp_code(rx_adp_code), .rx_adp_vld(rx_adp_vld)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: transmit PCM bits in launch order (R3).
    initial forever begin
        @(posedge pcm_bclk); #1;
        if (pcm_tx_oe) begin
            if (q_ptx.size() == 0) check(0, "R3", "unexpected tx pcm bit", 32'(pcm_tx_sd), 0);
            else begin
                bit e;
                e = q_ptx.pop_front();
                check(pcm_tx_sd == e, "R3", "tx pcm bit", 32'(pcm_tx_sd), 32'(e));
            end
        end
    end

    // Monitor: received PCM words (R7, R8).
    initial forever begin
        @(posedge pcm_bclk); #1;
        if (rx_pcm_vld) begin
            if (q_prx.size() == 0) check(0, "R8", "unexpected rx pcm strobe", 32'(rx_pcm_word), 0);
            else begin
                logic [13:0] e;
                e = q_prx.pop_front();
                check(rx_pcm_word == e, "R7", "rx pcm word", 32'(rx_pcm_word), 32'(e));
            end
        end
    end

    // Monitor: received ADPCM codes (R7, R8).
    initial forever begin
        @(posedge adp_bclk); #1;
        if (rx_adp_vld) begin
            if (q_arx.size() == 0) check(0, "R8", "unexpected rx adpcm strobe", 32'(rx_adp_code), 0);
            else begin
                logic [3:0] e;
                e = q_arx.pop_front();
                check(rx_adp_code == e, "R7", "rx adpcm code", 32'(rx_adp_code), 32'(e));
            end
        end
    end

    // One frame on both directions; live=0 expects a silent port.
    task automatic frame(input bit lin, input logic [13:0] txw, input logic [3:0] txc,
                         input logic [13:0] rxw, input logic [3:0] rxc,
                         input bit live, input int hold);
        logic [13:0] tx_al, rx_al;
        int len;
        len   = lin ? 14 : 8;
        tx_al = lin ? txw : {txw[7:0], 6'b0};
        rx_al = lin ? rxw : {rxw[7:0], 6'b0};
        if (live) begin
            for (int k = 0; k < len; k++) q_ptx.push_back(tx_al[13-k]);
            q_atx.push_back(txc);
            held_prx = lin ? rxw : {6'b0, rxw[7:0]};
            held_arx = rxc;
            q_prx.push_back(held_prx);
            q_arx.push_back(held_arx);
        end
        @(posedge adp_bclk); #1;
        lin_sel = lin; tx_pcm_word = txw; tx_adp_code = txc;
        tx_fsync = 1'b1; rx_fsync = 1'b1;
        fork
            begin #(8*hold); tx_fsync = 1'b0; rx_fsync = 1'b0; end
            begin
                for (int k = 0; k < len + 4; k++) begin
                    pcm_rx_sd = (k < len) ? rx_al[13-k] : 1'b1;
                    @(posedge pcm_bclk); #1;
                end
                pcm_rx_sd = 1'b0;
            end
            begin
                for (int k = 0; k < 6; k++) begin
                    adp_rx_sd = (k < 4) ? rxc[3-k] : ~rxc[0];
                    @(posedge adp_bclk); #1;
                end
                adp_rx_sd = 1'b0;
            end
            begin
                @(posedge pcm_bclk); #1;
                check(pcm_tx_oe == live, "R3", "enable on first launch edge", 32'(pcm_tx_oe), 32'(live));
            end
            begin
                logic [3:0] got;
                #4;
                check(adp_tx_pull == 1'b0, "R6", "adpcm line released before launch", 32'(adp_tx_pull), 0);
                @(posedge adp_bclk); #1;
                for (int k = 0; k < 4; k++) begin
                    got[3-k] = ~adp_tx_pull;
                    @(posedge adp_bclk); #1;
                end
                check(adp_tx_pull == 1'b0, "R6", "adpcm line released after code", 32'(adp_tx_pull), 0);
                if (live) begin
                    logic [3:0] e;
                    e = q_atx.pop_front();
                    check(got == e, "R6", "tx adpcm code", 32'(got), 32'(e));
                end else begin
                    check(got == 4'hF, "R10", "adpcm pulled in power-down", 32'(got), 32'hF);
                end
            end
        join
        repeat (4) @(posedge adp_bclk);
        #1;
        check(q_ptx.size() == 0, "R3", "tx pcm bits left", 32'(q_ptx.size()), 0);
        check(q_prx.size() == 0 && q_arx.size() == 0, "R7", "rx words not delivered",
              32'(q_prx.size() + q_arx.size()), 0);
        check(pcm_tx_oe == 1'b0, "R3", "enable after frame", 32'(pcm_tx_oe), 0);
        check(rx_pcm_word == held_prx, "R9", "held pcm word", 32'(rx_pcm_word), 32'(held_prx));
        check(rx_adp_code == held_arx, "R9", "held adpcm code", 32'(rx_adp_code), 32'(held_arx));
    endtask

    // Power-down dropped during the second transmit PCM bit (R10).
    task automatic pd_midframe();
        q_ptx.push_back(1'b1);
        q_ptx.push_back(1'b0);
        @(posedge adp_bclk); #1;
        lin_sel = 1'b1; tx_pcm_word = 14'h2AAA; tx_adp_code = 4'h0;
        tx_fsync = 1'b1;
        #8;
        tx_fsync = 1'b0;
        check(adp_tx_pull == 1'b1, "R6", "zero bit pulls line", 32'(adp_tx_pull), 1);
        #2;
        pdn_n = 1'b0;
        #0.5;
        check(pcm_tx_oe == 1'b0, "R10", "pcm enable released at once", 32'(pcm_tx_oe), 0);
        check(adp_tx_pull == 1'b0, "R10", "adpcm line released at once", 32'(adp_tx_pull), 0);
        repeat (10) @(posedge adp_bclk);
        #1;
        check(q_ptx.size() == 0, "R10", "bits before power-down", 32'(q_ptx.size()), 0);
        check(pcm_tx_oe == 1'b0 && adp_tx_pull == 1'b0, "R10", "quiet in power-down",
              32'({pcm_tx_oe, adp_tx_pull}), 0);
        pdn_n = 1'b1;
    endtask

    initial begin
        #200000;
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge adp_bclk);
        #1;
        check(pcm_tx_oe == 1'b0, "R1", "reset pcm enable", 32'(pcm_tx_oe), 0);
        check(adp_tx_pull == 1'b0, "R1", "reset adpcm line", 32'(adp_tx_pull), 0);
        check(rx_pcm_vld == 1'b0 && rx_adp_vld == 1'b0, "R1", "reset strobes",
              32'({rx_pcm_vld, rx_adp_vld}), 0);
        check(rx_pcm_word == 14'h0, "R1", "reset pcm word", 32'(rx_pcm_word), 0);
        check(rx_adp_code == 4'h0, "R1", "reset adpcm code", 32'(rx_adp_code), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge adp_bclk);

        frame(1'b1, 14'h1A5C, 4'h9, 14'h2B3D, 4'h6, 1'b1, 1);   // R3 R6 R7 R8
        frame(1'b1, 14'h1FFF, 4'h0, 14'h2000, 4'hF, 1'b1, 1);   // R5 full scale
        frame(1'b1, 14'h2000, 4'hF, 14'h1FFF, 4'h0, 1'b1, 2);   // R2 long sync, R5
        frame(1'b1, 14'h0000, 4'hA, 14'h0000, 4'h5, 1'b1, 1);   // R5 zero
        frame(1'b0, 14'h3FA5, 4'h3, 14'h3F5A, 4'hC, 1'b1, 1);   // R4 companded
        frame(1'b0, 14'h0081, 4'h7, 14'h00FF, 4'h1, 1'b1, 2);   // R4 R2

        pd_midframe();                                          // R10
        @(posedge adp_bclk); #1;
        pdn_n = 1'b0;
        frame(1'b1, 14'h1234, 4'h0, 14'h0F0F, 4'h3, 1'b0, 1);   // R10 R9
        @(posedge adp_bclk); #1;
        pdn_n = 1'b1;
        frame(1'b1, 14'h0F0F, 4'hC, 14'h3333, 4'hA, 1'b1, 1);   // R10 recovery

        @(posedge adp_bclk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge adp_bclk);
        #1;
        check(rx_pcm_word == 14'h0 && rx_adp_code == 4'h0, "R1", "mid-run reset clears words",
              32'({rx_pcm_word, rx_adp_code}), 0);
        rst_n = 1'b1;
        held_prx = '0;
        held_arx = '0;
        frame(1'b0, 14'h00C3, 4'h5, 14'h003C, 4'hE, 1'b1, 1);   // R4 after reset

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule